// File: doc/BRIEF.md
# Bus Cycle Timer

This block sets the clock-by-clock timing of the bus cycles of an 8-bit processor. The core raises a request with a cycle kind: instruction fetch, memory read, memory write, port read or port write. The timer marks the clock at which outside events are evaluated (the sample strobe) and the last clock of the cycle (the done strobe). It also keeps a running tally of bus clocks. Each kind splits into a fixed number of clocks before the sample point and a fixed number after it. A device can stretch the cycle by returning a wait count, and those clocks are added after the sample point.

Each instruction fetch steps a 7-bit refresh counter. The core may load this counter at any time. Its top bit is never touched by the stepping. In the variant with an internal control port, a port write to one chosen low address byte stays inside the processor. It produces no sample strobe and ignores the wait count. It still takes the normal port-cycle length and raises a control-write strobe on its last clock. Only one cycle is in flight at a time. A request made while a cycle runs is taken only in that cycle's last clock, so back-to-back cycles have no gap.

Top module: `bus_cycle_timer`

## Requirements
- R1: While reset is held and after it is released with no request, busy, sample_stb, done_stb and ctl_wr_stb are 0, clk_count is 0 and refresh is 0.
- R2: A memory read (req_kind 1) or memory write (req_kind 2) with zero waits keeps busy high for 3 clocks: sample_stb in the 1st and done_stb in the 3rd.
- R3: An instruction fetch (req_kind 0) with zero waits lasts 4 clocks: sample_stb in the 1st and done_stb in the 4th.
- R4: A port read (req_kind 3) or a port write (req_kind 4) to any other address lasts 4 clocks with zero waits: sample_stb in the 2nd and done_stb in the 4th. Codes 5 to 7 time like a memory read.
- R5: With waits enabled, wait_cnt is taken in the sample_stb clock and adds that many clocks after the sample point. The done clock moves later by wait_cnt.
- R6: Each accepted fetch adds one to refresh[6:0], wrapping from 127 to 0, and leaves refresh[7] unchanged.
- R7: rfsh_ld loads rfsh_ld_val into refresh on the next edge. This load wins over a fetch accepted on the same edge.
- R8: A port write whose low address byte equals CTRL_PORT (0xBB by default) gives no sample_stb and ignores wait_cnt. It lasts 4 clocks and raises ctl_wr_stb together with done_stb.
- R9: A request is accepted only when idle or in a done_stb clock. Requests at other times are ignored. A request held through a done_stb clock starts the next cycle with no idle clock between.
- R10: clk_count increases by one on every clock in which busy is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 port read, 4 port write |
| req_port_lo | input | 8 | Low address byte of the request, used for control-port detection |
| wait_cnt | input | WAIT_W | Wait clocks returned by the addressed device |
| rfsh_ld | input | 1 | Load the refresh counter |
| rfsh_ld_val | input | 8 | Value for a refresh load |
| busy | output | 1 | A cycle is in progress |
| sample_stb | output | 1 | Clock at which outside events are evaluated |
| done_stb | output | 1 | Last clock of the cycle |
| ctl_wr_stb | output | 1 | Last clock of an internally absorbed control-port write |
| clk_count | output | CNT_W | Running count of bus clocks |
| refresh | output | 8 | Refresh counter |

## Verification
The bench goes after the points where a split is easy to get wrong:
- A port cycle whose sample strobe landed in its first clock would show sample_stb one clock early.
- A wait count added before the sample point would move the strobe itself, not only the done clock.
- A design that sampled the wait count at acceptance rather than at the strobe would miss a value that changes between the two.
- Held requests across a done clock catch both a lost cycle and an idle clock inserted between cycles.
- Over a hundred fetches, together with loads of 0x7F and 0xFF, would show a carry leaking into bit 7.
- A control-port write with a large wait would show a stray strobe or a stretched cycle if absorption were not handled.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;

   typedef enum logic [2:0] {
      BK_FETCH = 3'd0,
      BK_MRD   = 3'd1,
      BK_MWR   = 3'd2,
      BK_IORD  = 3'd3,
      BK_IOWR  = 3'd4
   } bus_kind_e;

   // clocks up to and including the sample clock
   function automatic logic [1:0] lead_clocks(input logic [2:0] kind);
      case (kind)
         BK_IORD, BK_IOWR: lead_clocks = 2'd2;
         default:          lead_clocks = 2'd1;
      endcase
   endfunction

   // clocks after the sample clock, before any waits
   function automatic logic [1:0] tail_clocks(input logic [2:0] kind);
      case (kind)
         BK_FETCH: tail_clocks = 2'd3;
         default:  tail_clocks = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/bcyc_port_match.sv
module bcyc_port_match #(
   parameter bit         ABSORB_EN = 1'b1,
   parameter logic [7:0] CTRL_PORT = 8'hBB
) (
   input  logic [2:0] kind,
   input  logic [7:0] port_lo,
   output logic       hit
);
   import bcyc_pkg::*;

   generate
      if (ABSORB_EN) begin : g_absorb
         assign hit = (kind == BK_IOWR) && (port_lo == CTRL_PORT);
      end else begin : g_plain
         assign hit = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bcyc_phase_timer.sv
module bcyc_phase_timer #(
   parameter int WAIT_W  = 4,
   parameter bit WAIT_EN = 1'b1,
   parameter int REM_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        start_lead,
   input  logic [1:0]        start_tail,
   input  logic              start_quiet,
   input  logic [WAIT_W-1:0] wait_cnt,
   output logic              busy,
   output logic              sample_stb,
   output logic              done_stb,
   output logic              quiet
);

   logic             busy_q, lead_q, quiet_q;
   logic [1:0]       tail_q;
   logic [REM_W-1:0] rem_q;
   logic [REM_W-1:0] wait_add;
   logic             last_clk;

   generate
      if (WAIT_EN) begin : g_wait
         assign wait_add = quiet_q ? '0 : REM_W'(wait_cnt);
      end else begin : g_nowait
         assign wait_add = '0;
      end
   endgenerate

   assign last_clk   = (rem_q == REM_W'(1));
   assign busy       = busy_q;
   assign quiet      = quiet_q;
   assign sample_stb = busy_q & lead_q & last_clk & ~quiet_q;
   assign done_stb   = busy_q & ~lead_q & last_clk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         lead_q  <= 1'b0;
         quiet_q <= 1'b0;
         tail_q  <= '0;
         rem_q   <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         lead_q  <= 1'b1;
         quiet_q <= start_quiet;
         tail_q  <= start_tail;
         rem_q   <= REM_W'(start_lead);
      end else if (busy_q) begin
         if (lead_q && last_clk) begin
            lead_q <= 1'b0;
            rem_q  <= REM_W'(tail_q) + wait_add;
         end else if (last_clk) begin
            busy_q <= 1'b0;
         end else begin
            rem_q <= rem_q - REM_W'(1);
         end
      end
   end

endmodule

// File: rtl/bcyc_refresh.sv
module bcyc_refresh (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fetch_go,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] rfsh
);

   logic [7:0] rfsh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rfsh_q <= '0;
      end else if (ld) begin
         rfsh_q <= ld_val;
      end else if (fetch_go) begin
         rfsh_q <= {rfsh_q[7], rfsh_q[6:0] + 7'd1};
      end
   end

   assign rfsh = rfsh_q;

endmodule

// File: rtl/bcyc_clock_tally.sv
module bcyc_clock_tally #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    count_q <= '0;
      else if (tick) count_q <= count_q + CNT_W'(1);
   end

   assign count = count_q;

endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
   parameter int         WAIT_W    = 4,
   parameter int         CNT_W     = 16,
   parameter bit         WAIT_EN   = 1'b1,
   parameter bit         ABSORB_EN = 1'b1,
   parameter logic [7:0] CTRL_PORT = 8'hBB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [7:0]        req_port_lo,
   input  logic [WAIT_W-1:0] wait_cnt,
   input  logic              rfsh_ld,
   input  logic [7:0]        rfsh_ld_val,
   output logic              busy,
   output logic              sample_stb,
   output logic              done_stb,
   output logic              ctl_wr_stb,
   output logic [CNT_W-1:0]  clk_count,
   output logic [7:0]        refresh
);
   import bcyc_pkg::*;

   localparam int REM_W = $clog2(4 + (1 << WAIT_W));

   generate
      if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait
         $error("WAIT_W must lie in 1..8");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W must be at least 4");
      end
   endgenerate

   logic accept, hit, quiet;

   assign accept = req_valid & (~busy | done_stb);

   bcyc_port_match #(
      .ABSORB_EN (ABSORB_EN),
      .CTRL_PORT (CTRL_PORT)
   ) i_match (
      .kind    (req_kind),
      .port_lo (req_port_lo),
      .hit     (hit)
   );

   bcyc_phase_timer #(
      .WAIT_W  (WAIT_W),
      .WAIT_EN (WAIT_EN),
      .REM_W   (REM_W)
   ) i_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_lead  (lead_clocks(req_kind)),
      .start_tail  (tail_clocks(req_kind)),
      .start_quiet (hit),
      .wait_cnt    (wait_cnt),
      .busy        (busy),
      .sample_stb  (sample_stb),
      .done_stb    (done_stb),
      .quiet       (quiet)
   );

   assign ctl_wr_stb = done_stb & quiet;

   bcyc_refresh i_rfsh (
      .clk      (clk),
      .rst_n    (rst_n),
      .fetch_go (accept && (req_kind == BK_FETCH)),
      .ld       (rfsh_ld),
      .ld_val   (rfsh_ld_val),
      .rfsh     (refresh)
   );

   bcyc_clock_tally #(.CNT_W(CNT_W)) i_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (busy),
      .count (clk_count)
   );

endmodule

// File: rtl/bcyc_checker.sv
module bcyc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             sample_stb,
   input logic             done_stb,
   input logic             ctl_wr_stb,
   input logic             rfsh_ld,
   input logic [CNT_W-1:0] clk_count,
   input logic [7:0]       refresh
);

   a_r9_strobes_need_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb | done_stb) |-> busy);

   a_r5_no_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !done_stb);

   a_r2_min_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> !done_stb);

   a_r8_ctl_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_stb |-> done_stb && !sample_stb);

   a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> clk_count == CNT_W'($past(clk_count) + 1'b1));

   a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(clk_count));

   a_r6_bit7_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_ld |=> refresh[7] == $past(refresh[7]));

endmodule

bind bus_cycle_timer bcyc_checker #(.CNT_W(CNT_W)) i_bcyc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .sample_stb (sample_stb),
   .done_stb   (done_stb),
   .ctl_wr_stb (ctl_wr_stb),
   .rfsh_ld    (rfsh_ld),
   .clk_count  (clk_count),
   .refresh    (refresh)
);

// File: tb/test_bus_cycle_timer.sv
module test_bus_cycle_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_kind = 3'd0;
   logic [7:0] req_port_lo = 8'h00;
   logic [3:0] wait_cnt = 4'd0;
   logic       rfsh_ld = 1'b0;
   logic [7:0] rfsh_ld_val = 8'h00;
   logic       busy, sample_stb, done_stb, ctl_wr_stb;
   logic [15:0] clk_count;
   logic [7:0]  refresh;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string tag = "R1";

   always #10 clk = ~clk;

   bus_cycle_timer i_bus_cycle_timer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_port_lo(req_port_lo), .wait_cnt(wait_cnt), .rfsh_ld(rfsh_ld),
      .rfsh_ld_val(rfsh_ld_val), .busy(busy), .sample_stb(sample_stb),
      .done_stb(done_stb), .ctl_wr_stb(ctl_wr_stb), .clk_count(clk_count),
      .refresh(refresh)
   );

   // behavioural reference model
   bit         m_busy = 0;
   int         m_pos = 0, m_lead = 0, m_tail = 0, m_wait = 0;
   bit         m_quiet = 0;
   logic [15:0] m_cnt = 0;
   logic [7:0]  m_rf = 0;

   function automatic bit m_done();
      return m_busy && (m_pos > m_lead) && (m_pos == m_lead + m_tail + m_wait);
   endfunction
   function automatic bit m_sample();
      return m_busy && (m_pos == m_lead) && !m_quiet;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_pos = 0; m_cnt = 0; m_rf = 0; m_quiet = 0;
      end else begin
         bit acc;
         bit fin;
         acc = req_valid && (!m_busy || m_done());
         fin = m_done();
         if (m_busy) m_cnt = m_cnt + 16'd1;
         if (rfsh_ld) m_rf = rfsh_ld_val;
         else if (acc && req_kind == 3'd0) m_rf = (m_rf & 8'h80) | ((m_rf + 8'd1) & 8'h7f);
         if (m_busy) begin
            if (m_pos == m_lead) m_wait = m_quiet ? 0 : int'(wait_cnt);
            if (fin) m_busy = 0;
            else m_pos++;
         end
         if (acc) begin
            m_busy = 1; m_pos = 1; m_wait = 0;
            m_lead = (req_kind == 3'd3 || req_kind == 3'd4) ? 2 : 1;
            m_tail = (req_kind == 3'd0) ? 3 : 2;
            m_quiet = (req_kind == 3'd4) && (req_port_lo == 8'hBB);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      chk(tag, "busy", int'(busy), int'(m_busy));
      chk(tag, "sample_stb", int'(sample_stb), int'(m_sample()));
      chk(tag, "done_stb", int'(done_stb), int'(m_done()));
      chk(tag == "R1" ? "R1" : "R8", "ctl_wr_stb", int'(ctl_wr_stb), int'(m_done() && m_quiet));
      chk(tag == "R1" ? "R1" : "R10", "clk_count", int'(clk_count), int'(m_cnt));
      chk(tag == "R7" ? "R7" : "R6", "refresh", int'(refresh), int'(m_rf));
   end

   task automatic run_req(input int k, input int port, input int w);
      @(negedge clk);
      while (m_busy) @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(k); req_port_lo = 8'(port); wait_cnt = 4'(w);
      @(negedge clk);
      req_valid = 1'b0;
      while (m_busy) @(negedge clk);
   endtask

   task automatic load_rf(input int v);
      @(negedge clk);
      rfsh_ld = 1'b1; rfsh_ld_val = 8'(v);
      @(negedge clk);
      rfsh_ld = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      tag = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      tag = "R2";
      run_req(1, 8'h12, 0);
      run_req(2, 8'h34, 0);
      run_req(6, 8'h00, 0);
      tag = "R3";
      run_req(0, 8'h00, 0);
      run_req(0, 8'hBB, 0);
      tag = "R4";
      run_req(3, 8'hBB, 0);
      run_req(4, 8'hBA, 0);
      run_req(3, 8'h01, 0);

      tag = "R5";
      run_req(1, 8'h00, 3);
      run_req(3, 8'h00, 2);
      run_req(0, 8'h00, 15);
      run_req(4, 8'h10, 7);
      // wait value changes between acceptance and the sample clock
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd3; wait_cnt = 4'd0;
      @(negedge clk);
      req_valid = 1'b0; wait_cnt = 4'd5;
      while (m_busy) @(negedge clk);

      tag = "R8";
      run_req(4, 8'hBB, 9);
      run_req(4, 8'hBB, 0);

      tag = "R9";
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd0; wait_cnt = 4'd1;
      repeat (7) @(negedge clk);
      req_kind = 3'd3;
      repeat (6) @(negedge clk);
      req_kind = 3'd2;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
      while (m_busy) @(negedge clk);
      // request pulses during a busy cycle are ignored
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd1; wait_cnt = 4'd4;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd0;
      @(negedge clk);
      req_valid = 1'b0;
      while (m_busy) @(negedge clk);

      tag = "R6";
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd0; wait_cnt = 4'd0;
      repeat (4 * 135) @(negedge clk);
      req_valid = 1'b0;
      while (m_busy) @(negedge clk);

      tag = "R7";
      load_rf(8'h7F);
      run_req(0, 0, 0);
      load_rf(8'hFF);
      run_req(0, 0, 0);
      run_req(0, 0, 0);
      @(negedge clk);
      rfsh_ld = 1'b1; rfsh_ld_val = 8'h10;
      req_valid = 1'b1; req_kind = 3'd0; wait_cnt = 4'd0;
      @(negedge clk);
      rfsh_ld = 1'b0; req_valid = 1'b0;
      while (m_busy) @(negedge clk);
      load_rf(8'hC5);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule